// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block derives the bit timing for a serial transmitter and receiver from a single peripheral clock. The first stage divides that clock by a power of two that software selects. The second stage is a 12-bit programmable divider. It runs on the prescaled enable and produces two single-cycle enable pulses in the input clock domain. The receive-side tick fires once every N prescaled periods. The baud tick fires on every second receive-side tick, so its rate is the prescaled rate divided by 2N. Both pulses come from one counter, so they stay phase-aligned.

Both settings sit in one 16-bit control word, which is read and written as a whole. The register interface takes a module-enable input, `run_en`. While `run_en` is high the block counts and register writes are dropped. While it is low every counter is held at zero and the word may be rewritten.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the control word reads 0xEFFF (prescaler code 7, divider code 0xFFF), and `baud_tick` and `rx_tick` are low.
- R2: The prescaler code k is held in bits 15:13. The prescaled enable fires once every 2^k input cycles, and code 0 fires every cycle.
- R3: Bit 12 of the control word always reads 0, even after a write of 1 to it.
- R4: For a divider code N of 3 or more (bits 11:0), `rx_tick` fires once every N·2^k input cycles.
- R5: Divider codes 0, 1 and 2 all act as N = 2, giving `rx_tick` every 2·2^k cycles and `baud_tick` every 4·2^k cycles.
- R6: `baud_tick` fires once every 2·N·2^k cycles, and only in a cycle in which `rx_tick` also fires (every second one).
- R7: Divider code 0xFFF gives `rx_tick` every 4095·2^k cycles and `baud_tick` every 8190·2^k cycles.
- R8: A write presented while `run_en` is high leaves the control word unchanged. A write while `run_en` is low stores all bits except bit 12.
- R9: While `run_en` is low, neither tick fires. Counting the first cycle with `run_en` high as cycle 1, the first `rx_tick` falls in cycle N·2^k and the first `baud_tick` in cycle 2·N·2^k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Module enable: high counts, low holds counters and permits writes |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word |
| baud_tick | output | 1 | Transmit/receive bit-rate enable pulse |
| rx_tick | output | 1 | Receive-side enable pulse at twice the baud rate |

## Verification
The assertions assume two things about the inputs. Configuration changes arrive only while `run_en` is low, and `run_en` is low after reset, so the counters start from zero when counting begins. The assertions also rely on the clamped divider value never being below 2. The stimulus writes each setting with `run_en` low, checks the readback, and raises `run_en` just after a clock edge. It then measures tick positions over four receive periods. The locked-write case is the only stimulus that strobes `wr_en` with `run_en` high, and it checks that the stored word does not change.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int CTRL_W = 16;
  localparam int PRS_W  = 3;
  localparam int DIV_W  = 12;
  localparam int RSV_W  = CTRL_W - PRS_W - DIV_W;
  localparam int MIN_DIV = 2;

  // Smallest codes collapse onto the minimum divide ratio.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] code);
    eff_div = (code < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : code;
  endfunction

  // Terminal count of the prescaler: 2^k - 1.
  function automatic logic [(1<<PRS_W)-1:0] pre_last(input logic [PRS_W-1:0] k);
    pre_last = ((1<<PRS_W)'(1) << k) - (1<<PRS_W)'(1);
  endfunction

  // Control word assembly with reserved bits forced to zero.
  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic [PRS_W-1:0] k,
                                                  input logic [DIV_W-1:0] n);
    pack_ctrl = {k, {RSV_W{1'b0}}, n};
  endfunction
endpackage

// File: rtl/baudgen_ctrl_reg.sv
module baudgen_ctrl_reg
  import baudgen_pkg::*;
#(
  parameter logic [PRS_W-1:0] RST_PRS = '1,
  parameter logic [DIV_W-1:0] RST_DIV = '1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [PRS_W-1:0]  prs_code,
  output logic [DIV_W-1:0]  div_code,
  output logic [CTRL_W-1:0] rd_data
);
  localparam int PRS_LSB = CTRL_W - PRS_W;

  logic wr_accept;
  assign wr_accept = wr_en & ~run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prs_code <= RST_PRS;
      div_code <= RST_DIV;
    end else if (wr_accept) begin
      prs_code <= wr_data[CTRL_W-1:PRS_LSB];
      div_code <= wr_data[DIV_W-1:0];
    end
  end

  assign rd_data = pack_ctrl(prs_code, div_code);

  // R8: writes during operation are locked out
  a_r8_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wr_en) |=> ($stable(prs_code) && $stable(div_code)));

  // R8: writes while idle are stored
  a_r8_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && wr_en) |=> (div_code == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/baudgen_prescaler.sv
module baudgen_prescaler
  import baudgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PRS_W-1:0] prs_code,
  output logic             pre_tick
);
  localparam int CNT_W = 1 << PRS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last    = pre_last(prs_code);
  assign at_last = (cnt_q == last);
  assign pre_tick = run_en & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run_en)  cnt_q <= '0;
    else if (at_last)  cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter never passes the terminal count
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  // R9: idle keeps the counter cleared
  a_r9_pre_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0));
endmodule

// File: rtl/baudgen_divider.sv
module baudgen_divider
  import baudgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] div_code,
  output logic             rx_tick,
  output logic             baud_tick
);
  logic [DIV_W-1:0] n_eff;
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign n_eff = eff_div(div_code);
  assign wrap  = (cnt_q == n_eff - 1'b1);
  assign rx_tick   = pre_tick & wrap;
  assign baud_tick = rx_tick & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_en) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (pre_tick) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) phase_q <= ~phase_q;
    end
  end

  // R4: count stays inside the clamped range
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_eff);

  // R5: clamp never yields a ratio below two
  a_r5_min_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    n_eff >= DIV_W'(MIN_DIV));

  // R6: baud tick only on a receive tick
  a_r6_baud_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> rx_tick);

  // R6: consecutive receive ticks alternate baud phase
  a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && run_en) |=> (phase_q != $past(phase_q) || !run_en));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter logic [PRS_W-1:0] RST_PRS = 3'd7,
  parameter logic [DIV_W-1:0] RST_DIV = 12'hFFF
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        baud_tick,
  output logic        rx_tick
);
  logic [PRS_W-1:0] prs_code;
  logic [DIV_W-1:0] div_code;
  logic             pre_tick;

  baudgen_ctrl_reg #(.RST_PRS(RST_PRS), .RST_DIV(RST_DIV)) u_reg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_data(wr_data), .prs_code(prs_code), .div_code(div_code),
    .rd_data(rd_data)
  );

  baudgen_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .prs_code(prs_code), .pre_tick(pre_tick)
  );

  baudgen_divider u_div (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_tick(pre_tick),
    .div_code(div_code), .rx_tick(rx_tick), .baud_tick(baud_tick)
  );

  // R4: a receive tick needs a prescaled enable
  a_r4_rx_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> pre_tick);

  // R9: nothing fires while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!rx_tick && !baud_tick && !pre_tick));

  // R3: reserved bit reads zero
  a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[12] == 1'b0);
endmodule

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        baud_tick, rx_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .baud_tick(baud_tick), .rx_tick(rx_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Raise enable and compare tick positions over four receive periods.
  task automatic run_case(input int k, input int code, input string req);
    int n, per, bad_rx, bad_bd, first_rx;
    logic [15:0] w;
    n = (code < 2) ? 2 : code;
    per = n * (1 << k);
    w = {k[2:0], 1'b0, code[11:0]};
    write_word(w);
    @(negedge clk);
    check({req, " readback"}, int'(rd_data), int'(w));
    bad_rx = 0; bad_bd = 0; first_rx = 0;
    @(posedge clk); #1;
    run_en = 1'b1;
    for (int c = 1; c <= 4 * per; c++) begin
      @(negedge clk);
      if (rx_tick && first_rx == 0) first_rx = c;
      if (rx_tick != ((c % per) == 0)) bad_rx++;
      if (baud_tick != ((c % (2 * per)) == 0)) bad_bd++;
    end
    check({req, " R9 first rx cycle"}, first_rx, per);
    check({req, " rx period mismatches"}, bad_rx, 0);
    check({req, " R6 baud period mismatches"}, bad_bd, 0);
    @(posedge clk); #1;
    run_en = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes[6];
    codes = '{0, 1, 2, 3, 5, 9};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset word", int'(rd_data), 16'hEFFF);
    check("R1 rx low", int'(rx_tick), 0);
    check("R1 baud low", int'(baud_tick), 0);

    // R3: reserved bit cannot be set
    write_word(16'hFFFF);
    @(negedge clk);
    check("R3 reserved bit", int'(rd_data), 16'hEFFF);

    // R2 R4 R5: sweep prescaler and small divider codes
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 6; i++)
        run_case(k, codes[i], (codes[i] < 3) ? "R5 R2 clamp" : "R4 R2 divide");
    run_case(7, 3, "R2 R4 max prescale");
    run_case(5, 17, "R2 R4 mid");
    run_case(0, 4095, "R7 max divider");
    run_case(1, 4095, "R7 max divider k1");

    // R8: write while enabled is dropped
    write_word(16'h2007);
    @(posedge clk); #1;
    run_en = 1'b1;
    wr_en = 1'b1; wr_data = 16'hA123;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(posedge clk); #1;
    run_en = 1'b0;
    @(negedge clk);
    check("R8 locked write", int'(rd_data), 16'h2007);

    // R9: idle with the fastest setting produces no ticks
    write_word(16'h0000);
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (rx_tick || baud_tick) seen++;
      end
      check("R9 idle ticks", seen, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule